// File: doc/BRIEF.md
# CAN Controller Mode-Handshake Sequencer

This block sits between a host CPU and a CAN protocol engine and owns the operating mode of the controller. The host writes request bits for sleep and initialization. The block holds each request until it can grant it, raises a matching acknowledge, and drives the engine's abort and enable controls, the transmit force-recessive control and a soft reset for the registers that initialization puts back to their defaults. It also gates configuration writes so they land only while initialization is fully acknowledged.

An initialization request takes effect at once. The transmit line is forced recessive and the engine is aborted in the same cycle. A sleep request waits until no frame is being received and every transmit buffer is empty. When the host leaves initialization, the block holds the engine off until it has seen a run of recessive bits. When the node is bus-off, it waits for many such runs instead. While asleep, the block can wake itself on a dominant bit and raise a wake-up flag.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, `sleep_req`, `sleep_ack`, `init_req`, `init_ack`, `wup_flag`, `tx_force_rec` and `cfg_wr_open` are 0, and `pe_enable` is 1.
- R2: `init_ack` is 1 from the clock after `init_req` becomes 1. A host write with `ctl_init_d`=0 while `init_ack`=0 leaves `init_req` at 1.
- R3: While `init_req`=1, `tx_force_rec` and `pe_abort` are 1 combinationally. `soft_rst` is 1 exactly in the cycles where `init_req`=1 and `init_ack`=0. The clock edge that ends such a cycle clears `wup_flag`.
- R4: `cfg_wr_open` is 1 only while `init_req`=1 and `init_ack`=1. `cfg_wr_en` equals `cfg_wr_req` when `cfg_wr_open`=1 and is 0 otherwise.
- R5: Once `init_req` is cleared, `init_ack` falls one clock later and resynchronization starts. A bit is counted on each `bit_stb`. `rx_bit`=1 is recessive and `rx_bit`=0 is dominant, and a dominant bit restarts the count. `pe_enable` returns after the edge of the 11th consecutive recessive bit.
- R6: If `bus_off`=1 when resynchronization starts, `pe_enable` returns only after 128 completed runs of 11 consecutive recessive bits.
- R7: `sleep_ack` rises only on an edge where `sleep_req`=1, `bus_rx_busy`=0, `tx_bufs_empty`=1, initialization is neither requested nor acknowledged, and no resynchronization is running. While `sleep_ack`=1, `pe_enable` is 0.
- R8: A write with `ctl_sleep_d`=0 while `sleep_ack`=0 leaves `sleep_req` at 1. A write with `ctl_sleep_d`=1 while `wup_flag`=1 leaves `sleep_req` at 0. After a permitted clear, `sleep_ack` falls one clock later.
- R9: While asleep with `wake_en`=1, a dominant bit clears `sleep_req` and `sleep_ack` and sets `wup_flag` on the same edge. With `wake_en`=0, the dominant bit changes nothing. A `wup_clr` pulse clears `wup_flag`.
- R10: `tx_force_rec` is also 1 whenever `cpu_stop`=1, or `cpu_wait`=1 and `stop_in_wait`=1.
- R11: If sleep and initialization are requested together, only `init_ack` rises. The pending sleep request is granted after initialization is left and resynchronization completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Host write strobe for the request bits |
| ctl_sleep_d | input | 1 | Sleep request write data |
| ctl_init_d | input | 1 | Initialization request write data |
| wake_en | input | 1 | Enable wake-up on bus activity |
| wup_clr | input | 1 | Clear the wake-up flag |
| rx_bit | input | 1 | Sampled receive bit, 1 = recessive |
| bit_stb | input | 1 | One-cycle strobe per bit time |
| bus_rx_busy | input | 1 | A frame is being received |
| tx_bufs_empty | input | 1 | All transmit buffers are empty |
| bus_off | input | 1 | Node is in the bus-off state |
| cpu_stop | input | 1 | CPU is in stop mode |
| cpu_wait | input | 1 | CPU is in wait mode |
| stop_in_wait | input | 1 | Treat wait as stop for the controller |
| cfg_wr_req | input | 1 | Configuration register write strobe |
| sleep_req | output | 1 | Held sleep request |
| sleep_ack | output | 1 | Sleep mode entered |
| init_req | output | 1 | Held initialization request |
| init_ack | output | 1 | Initialization mode entered |
| wup_flag | output | 1 | Wake-up interrupt flag |
| tx_force_rec | output | 1 | Force the transmit line recessive |
| pe_abort | output | 1 | Abort the protocol engine's activity |
| pe_enable | output | 1 | Protocol engine may take part in traffic |
| soft_rst | output | 1 | Return selected registers to their defaults |
| cfg_wr_open | output | 1 | Configuration writes are permitted |
| cfg_wr_en | output | 1 | Gated configuration write strobe |

## Verification
A wrong request or acknowledge register shows within one clock, as a missing or early `init_ack`, `sleep_ack` or `cfg_wr_open`, or as a forbidden write that sticks. A wrong resynchronization counter shows only at the end of a run. `pe_enable` returns one bit early or late, and in bus-off recovery that error can stay hidden for more than a thousand bit times. The bench therefore counts whole runs and checks both the last bit before release and the bit that releases. A wrong wake-up path shows on the edge of the first dominant bit, through `sleep_req` and `wup_flag`.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  // Default lengths of the recessive run and the bus-off run count
  localparam int unsigned RUN_LEN_DEF = 11;
  localparam int unsigned BO_RUNS_DEF = 128;

  // One host write of the request bits
  typedef struct packed {
    logic sleep;
    logic init;
  } ctl_req_t;

endpackage

// File: rtl/can_init_ctl.sv
module can_init_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_init,
  output logic init_rq,
  output logic init_ak,
  output logic soft_rst,
  output logic exit_stb
);

  logic init_rq_n;
  logic init_ak_n;

  always_comb begin
    init_rq_n = init_rq;
    if (wr) begin
      if (wr_init) begin
        init_rq_n = 1'b1;
      end else if (init_ak) begin
        init_rq_n = 1'b0;
      end
    end
    // The acknowledge follows the request one clock later in both directions
    init_ak_n = init_rq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_rq <= 1'b0;
      init_ak <= 1'b0;
    end else begin
      init_rq <= init_rq_n;
      init_ak <= init_ak_n;
    end
  end

  assign soft_rst = init_rq & ~init_ak;
  assign exit_stb = ~init_rq & init_ak;

  AST_INIT_ACK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (init_rq && !init_ak) |=> init_ak); // R2
  AST_INIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (init_rq && !init_ak) |=> init_rq); // R2

endmodule

// File: rtl/can_sleep_ctl.sv
module can_sleep_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_sleep,
  input  logic grant_ok,
  input  logic wake_en,
  input  logic dom_seen,
  input  logic wup_clr,
  input  logic soft_rst,
  input  logic in_init,
  output logic sleep_rq,
  output logic sleep_ak,
  output logic wup_f
);

  logic sleep_rq_n;
  logic sleep_ak_n;
  logic wup_n;
  logic wake;

  assign wake = sleep_ak & wake_en & dom_seen & ~in_init;

  always_comb begin
    sleep_rq_n = sleep_rq;
    if (wr) begin
      if (wr_sleep) begin
        if (!wup_f) sleep_rq_n = 1'b1;
      end else if (sleep_ak) begin
        sleep_rq_n = 1'b0;
      end
    end

    sleep_ak_n = sleep_ak;
    if (!sleep_rq) begin
      sleep_ak_n = 1'b0;
    end else if (grant_ok) begin
      sleep_ak_n = 1'b1;
    end

    wup_n = wup_f;
    if (soft_rst) begin
      wup_n = 1'b0;
    end else if (wake) begin
      wup_n = 1'b1;
    end else if (wup_clr) begin
      wup_n = 1'b0;
    end

    if (wake) begin
      sleep_rq_n = 1'b0;
      sleep_ak_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_rq <= 1'b0;
      sleep_ak <= 1'b0;
      wup_f    <= 1'b0;
    end else begin
      sleep_rq <= sleep_rq_n;
      sleep_ak <= sleep_ak_n;
      wup_f    <= wup_n;
    end
  end

  AST_WUP_BLOCKS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wup_f && !sleep_rq) |=> !sleep_rq); // R8
  AST_SLEEP_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ak) |-> sleep_rq); // R7

endmodule

// File: rtl/can_resync.sv
module can_resync #(
  parameter int unsigned RUN_LEN = 11,
  parameter int unsigned BO_RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic bus_off,
  input  logic bit_stb,
  input  logic rx_bit,
  output logic busy
);

  localparam int unsigned RUN_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam int unsigned OCC_W = (BO_RUNS > 2) ? $clog2(BO_RUNS) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(BO_RUNS - 1);
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);
  localparam logic [OCC_W-1:0] OCC_ONE  = OCC_W'(1);

  logic             busy_n;
  logic             bo_lat, bo_lat_n;
  logic [RUN_W-1:0] run_cnt, run_cnt_n;
  logic [OCC_W-1:0] occ_cnt, occ_cnt_n;

  always_comb begin
    busy_n    = busy;
    bo_lat_n  = bo_lat;
    run_cnt_n = run_cnt;
    occ_cnt_n = occ_cnt;
    if (abort) begin
      busy_n    = 1'b0;
      run_cnt_n = '0;
      occ_cnt_n = '0;
    end else if (start) begin
      busy_n    = 1'b1;
      bo_lat_n  = bus_off;
      run_cnt_n = '0;
      occ_cnt_n = '0;
    end else if (busy && bit_stb) begin
      if (!rx_bit) begin
        run_cnt_n = '0;
      end else if (run_cnt == RUN_LAST) begin
        run_cnt_n = '0;
        if (!bo_lat || occ_cnt == OCC_LAST) begin
          busy_n    = 1'b0;
          occ_cnt_n = '0;
        end else begin
          occ_cnt_n = occ_cnt + OCC_ONE;
        end
      end else begin
        run_cnt_n = run_cnt + RUN_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bo_lat  <= 1'b0;
      run_cnt <= '0;
      occ_cnt <= '0;
    end else begin
      busy    <= busy_n;
      bo_lat  <= bo_lat_n;
      run_cnt <= run_cnt_n;
      occ_cnt <= occ_cnt_n;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_LAST); // R5
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_cnt <= OCC_LAST); // R6
  AST_DOMINANT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_stb && !rx_bit && !abort && !start) |=> (run_cnt == '0)); // R5

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int unsigned RUN_LEN = RUN_LEN_DEF,
  parameter int unsigned BO_RUNS = BO_RUNS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_sleep_d,
  input  logic ctl_init_d,
  input  logic wake_en,
  input  logic wup_clr,
  input  logic rx_bit,
  input  logic bit_stb,
  input  logic bus_rx_busy,
  input  logic tx_bufs_empty,
  input  logic bus_off,
  input  logic cpu_stop,
  input  logic cpu_wait,
  input  logic stop_in_wait,
  input  logic cfg_wr_req,
  output logic sleep_req,
  output logic sleep_ack,
  output logic init_req,
  output logic init_ack,
  output logic wup_flag,
  output logic tx_force_rec,
  output logic pe_abort,
  output logic pe_enable,
  output logic soft_rst,
  output logic cfg_wr_open,
  output logic cfg_wr_en
);

  ctl_req_t wr_req;
  logic     exit_stb;
  logic     resync_busy;
  logic     online;
  logic     bus_idle;
  logic     grant_ok;
  logic     dom_seen;
  logic     cpu_halt;

  assign wr_req.sleep = ctl_sleep_d;
  assign wr_req.init  = ctl_init_d;

  can_init_ctl u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wr_init  (wr_req.init),
    .init_rq  (init_req),
    .init_ak  (init_ack),
    .soft_rst (soft_rst),
    .exit_stb (exit_stb)
  );

  can_resync #(
    .RUN_LEN (RUN_LEN),
    .BO_RUNS (BO_RUNS)
  ) u_resync (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (exit_stb),
    .abort   (init_req),
    .bus_off (bus_off),
    .bit_stb (bit_stb),
    .rx_bit  (rx_bit),
    .busy    (resync_busy)
  );

  assign online   = ~init_ack & ~resync_busy;
  assign bus_idle = ~bus_rx_busy & tx_bufs_empty;
  assign grant_ok = bus_idle & online & ~init_req;
  assign dom_seen = bit_stb & ~rx_bit;

  can_sleep_ctl u_sleep (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wr_sleep (wr_req.sleep),
    .grant_ok (grant_ok),
    .wake_en  (wake_en),
    .dom_seen (dom_seen),
    .wup_clr  (wup_clr),
    .soft_rst (soft_rst),
    .in_init  (init_ack),
    .sleep_rq (sleep_req),
    .sleep_ak (sleep_ack),
    .wup_f    (wup_flag)
  );

  assign cpu_halt     = cpu_stop | (cpu_wait & stop_in_wait);
  assign tx_force_rec = init_req | ~online | sleep_ack | cpu_halt;
  assign pe_abort     = init_req;
  assign pe_enable    = online & ~sleep_ack & ~init_req;
  assign cfg_wr_open  = init_req & init_ack;
  assign cfg_wr_en    = cfg_wr_req & cfg_wr_open;

  AST_INIT_FORCES_TX: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> (tx_force_rec && pe_abort)); // R3
  AST_CFG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |-> (init_ack && init_req)); // R4
  AST_SLEEP_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> $past(!bus_rx_busy && tx_bufs_empty && !init_req)); // R7
  AST_RESYNC_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_req && init_ack) |=> (!init_ack && resync_busy)); // R5

endmodule

// File: tb/can_mode_seq_test.sv
module can_mode_seq_test;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr, ctl_sleep_d, ctl_init_d, wake_en, wup_clr;
  logic rx_bit, bit_stb, bus_rx_busy, tx_bufs_empty, bus_off;
  logic cpu_stop, cpu_wait, stop_in_wait, cfg_wr_req;
  logic sleep_req, sleep_ack, init_req, init_ack, wup_flag;
  logic tx_force_rec, pe_abort, pe_enable, soft_rst, cfg_wr_open, cfg_wr_en;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  can_mode_seq uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sleep_d(ctl_sleep_d),
    .ctl_init_d(ctl_init_d), .wake_en(wake_en), .wup_clr(wup_clr),
    .rx_bit(rx_bit), .bit_stb(bit_stb), .bus_rx_busy(bus_rx_busy),
    .tx_bufs_empty(tx_bufs_empty), .bus_off(bus_off), .cpu_stop(cpu_stop),
    .cpu_wait(cpu_wait), .stop_in_wait(stop_in_wait), .cfg_wr_req(cfg_wr_req),
    .sleep_req(sleep_req), .sleep_ack(sleep_ack), .init_req(init_req),
    .init_ack(init_ack), .wup_flag(wup_flag), .tx_force_rec(tx_force_rec),
    .pe_abort(pe_abort), .pe_enable(pe_enable), .soft_rst(soft_rst),
    .cfg_wr_open(cfg_wr_open), .cfg_wr_en(cfg_wr_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic s, input logic i);
    ctl_sleep_d = s;
    ctl_init_d  = i;
    ctl_wr      = 1'b1;
    @(negedge clk);
    ctl_wr      = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    rx_bit  = b;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    rx_bit  = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_run(input int n);
    for (int k = 0; k < n; k++) send_bit(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_wr = 0; ctl_sleep_d = 0; ctl_init_d = 0; wake_en = 0;
    wup_clr = 0; rx_bit = 1; bit_stb = 0; bus_rx_busy = 0; tx_bufs_empty = 1;
    bus_off = 0; cpu_stop = 0; cpu_wait = 0; stop_in_wait = 0; cfg_wr_req = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 sleep_ack", sleep_ack, 1'b0);
    chk("R1 init_ack", init_ack, 1'b0);
    chk("R1 wup_flag", wup_flag, 1'b0);
    chk("R1 tx_force_rec", tx_force_rec, 1'b0);
    chk("R1 pe_enable", pe_enable, 1'b1);
    chk("R1 cfg_wr_open", cfg_wr_open, 1'b0);
    cfg_wr_req = 1'b1; #1;
    chk("R4 cfg write dropped when running", cfg_wr_en, 1'b0);
    cfg_wr_req = 1'b0;
    tick();

    // R2/R3 init entry
    wr_ctl(1'b0, 1'b1);
    cfg_wr_req = 1'b1; #1;
    chk("R3 tx forced on init request", tx_force_rec, 1'b1);
    chk("R3 abort on init request", pe_abort, 1'b1);
    chk("R3 soft reset pulse", soft_rst, 1'b1);
    chk("R2 ack not yet", init_ack, 1'b0);
    chk("R4 cfg write dropped before ack", cfg_wr_en, 1'b0);
    cfg_wr_req = 1'b0;
    wr_ctl(1'b0, 1'b0);
    chk("R2 early clear ignored", init_req, 1'b1);
    chk("R2 ack set", init_ack, 1'b1);
    chk("R3 soft reset ends", soft_rst, 1'b0);
    cfg_wr_req = 1'b1; #1;
    chk("R4 cfg write open", cfg_wr_en, 1'b1);
    chk("R4 cfg_wr_open", cfg_wr_open, 1'b1);
    cfg_wr_req = 1'b0;

    // R5 exit and resync, with a dominant bit restarting the run
    wr_ctl(1'b0, 1'b0);
    chk("R5 init_req cleared", init_req, 1'b0);
    chk("R5 ack still set in exit cycle", init_ack, 1'b1);
    chk("R4 closed after clear", cfg_wr_open, 1'b0);
    tick();
    chk("R5 ack falls one clock later", init_ack, 1'b0);
    chk("R5 engine held off", pe_enable, 1'b0);
    send_run(10);
    send_bit(1'b0);
    send_run(10);
    chk("R5 not online after dominant restart", pe_enable, 1'b0);
    send_bit(1'b1);
    chk("R5 online after 11 recessive", pe_enable, 1'b1);
    chk("R5 tx released", tx_force_rec, 1'b0);

    // R6 bus-off recovery
    bus_off = 1'b1;
    wr_ctl(1'b0, 1'b1);
    tick();
    wr_ctl(1'b0, 1'b0);
    tick();
    for (int r = 0; r < 127; r++) send_run(11);
    send_run(10);
    chk("R6 still off one bit before end", pe_enable, 1'b0);
    send_bit(1'b1);
    chk("R6 online after 128 runs", pe_enable, 1'b1);
    bus_off = 1'b0;

    // R7/R8 sleep handshake
    bus_rx_busy = 1'b1;
    wr_ctl(1'b1, 1'b0);
    tick();
    chk("R7 no sleep while receiving", sleep_ack, 1'b0);
    wr_ctl(1'b0, 1'b0);
    chk("R8 early sleep clear ignored", sleep_req, 1'b1);
    bus_rx_busy = 1'b0; tx_bufs_empty = 1'b0;
    tick();
    chk("R7 no sleep with pending tx", sleep_ack, 1'b0);
    tx_bufs_empty = 1'b1;
    tick();
    chk("R7 sleep granted when idle", sleep_ack, 1'b1);
    chk("R7 engine off in sleep", pe_enable, 1'b0);

    // R9 wake-up
    wake_en = 1'b0;
    send_bit(1'b0);
    chk("R9 traffic ignored when wake disabled", sleep_ack, 1'b1);
    chk("R9 no flag when wake disabled", wup_flag, 1'b0);
    wake_en = 1'b1;
    send_bit(1'b0);
    chk("R9 wake clears sleep_req", sleep_req, 1'b0);
    chk("R9 wake clears sleep_ack", sleep_ack, 1'b0);
    chk("R9 wake sets flag", wup_flag, 1'b1);
    wr_ctl(1'b1, 1'b0);
    chk("R8 sleep set blocked by flag", sleep_req, 1'b0);
    wup_clr = 1'b1; tick(); wup_clr = 1'b0;
    chk("R9 flag cleared", wup_flag, 1'b0);
    wr_ctl(1'b1, 1'b0);
    chk("R8 sleep set after flag clear", sleep_req, 1'b1);
    tick();
    chk("R7 sleep ack again", sleep_ack, 1'b1);
    wr_ctl(1'b0, 1'b0);
    chk("R8 permitted clear", sleep_req, 1'b0);
    tick();
    chk("R8 ack falls one clock later", sleep_ack, 1'b0);

    // R3 init entry clears the wake flag
    wr_ctl(1'b1, 1'b0);
    tick();
    send_bit(1'b0);
    chk("R9 flag set again", wup_flag, 1'b1);
    wr_ctl(1'b0, 1'b1);
    tick();
    chk("R3 init clears wake flag", wup_flag, 1'b0);
    wr_ctl(1'b0, 1'b0);
    tick();
    send_run(11);
    chk("R5 online again", pe_enable, 1'b1);

    // R11 sleep and init together
    wr_ctl(1'b1, 1'b1);
    tick();
    chk("R11 init acked", init_ack, 1'b1);
    chk("R11 sleep held back", sleep_ack, 1'b0);
    wr_ctl(1'b1, 1'b0);
    tick();
    send_run(10);
    chk("R11 no sleep during resync", sleep_ack, 1'b0);
    send_bit(1'b1);
    chk("R11 sleep_req still pending", sleep_req, 1'b1);
    chk("R11 sleep granted after resync", sleep_ack, 1'b1);
    wr_ctl(1'b0, 1'b0);
    tick();
    chk("R8 leaving sleep", sleep_ack, 1'b0);

    // R10 sweep over stop/wait combinations
    for (int k = 0; k < 8; k++) begin
      cpu_stop     = k[2];
      cpu_wait     = k[1];
      stop_in_wait = k[0];
      #1;
      chk($sformatf("R10 combo %0d", k), tx_force_rec, k[2] | (k[1] & k[0]));
      tick();
    end
    cpu_stop = 0; cpu_wait = 0; stop_in_wait = 0;
    tick();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule